// File: doc/BRIEF.md
# Leading-Zero Anticipating Difference Normalizer

This block belongs to the add path of a floating-point adder. It handles the effective-subtraction case. Upstream logic has already aligned the two mantissas and swapped them so that the larger magnitude comes first. The block forms their difference and left-normalizes it. It reports how far it shifted, so that an exponent stage can adjust the exponent.

The block does not wait for the carry-propagate subtraction to finish and then count zeros. It works out the shift from the operands themselves. Each bit pair gives a signed digit in {-1, 0, +1}, and no carry moves between positions. A local indicator marks the likely leading position. A leading-zero counter on that indicator gives an estimated shift, and the estimate drives a barrel shifter that acts on the true difference. The estimate can fall short by one place, never more, and it never overshoots. A one-bit fix-up stage therefore tests the top bit of the shifted value and shifts one more place when that bit is clear. A zero difference is flagged on its own line, with the shift forced to the full width.

The result is registered once. Both the final shift count and the raw estimate are brought out.

Top module: `lzan_normalizer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `norm_mant`, `shift_total`, `shift_est` and `is_zero` are all cleared to zero on that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, which gives a latency of one clock.
- R3: Given `op_big >= op_small`, `norm_mant` equals `(op_big - op_small) << shift_total`, truncated to W bits.
- R4: For a nonzero difference, bit W-1 of `norm_mant` is 1.
- R5: For a nonzero difference, `shift_total` equals the number of leading zero bits of `op_big - op_small` seen as a W-bit value.
- R6: `shift_est` is taken from the carry-free signed digits of the operands, and it satisfies `shift_est <= shift_total <= shift_est + 1`. For example, with W=64, `op_big = 2^63` and `op_small = 3` give `shift_est = 0` and `shift_total = 1`.
- R7: When `op_big == op_small`, `is_zero` is 1, `norm_mant` is 0, and both `shift_total` and `shift_est` equal W.
- R8: In a cycle where `in_valid` is low, the inputs are ignored. On the next edge `norm_mant`, `shift_total`, `shift_est` and `is_zero` keep their values and `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| op_big | input | W | Larger aligned mantissa magnitude |
| op_small | input | W | Smaller aligned mantissa magnitude |
| out_valid | output | 1 | Result registers updated last edge |
| norm_mant | output | W | Normalized difference |
| shift_total | output | CW = clog2(W+1) | Total left shift applied |
| shift_est | output | CW | Shift predicted from the signed digits |
| is_zero | output | 1 | Difference was zero |

## Verification
The bench targets the cases where the digit pattern fools the predictor. One is a +1 digit followed by a zero and then borrows, where the estimate is one place short. There a missing or inverted fix-up would leave the top bit clear, or it would shift a normalized value one place too far. Further directed cases cover a borrow run that reaches bit 0 (difference 1), a difference with no leading zeros, and equal operands. In those cases a broken zero path would report a shift below W or a stray mantissa. Random pairs whose differences are spread over all magnitudes are checked against a bench-computed zero count. Idle cycles with changing inputs show that a design which loaded data without `in_valid` would change its held result.

// File: rtl/lzan_pkg.sv
package lzan_pkg;

    // Outcome of the one-bit fix-up stage
    typedef enum logic [1:0] {
        FIX_NONE = 2'd0,   // estimate was exact
        FIX_ONE  = 2'd1,   // estimate one short, extra shift applied
        FIX_ZERO = 2'd2    // difference zero, count forced
    } fix_kind_e;

    // Width of a count able to hold 0..w
    function automatic int unsigned count_width(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/lzan_digit_indicator.sv
// Carry-free signed-digit leading-position indicator.
// Digit i = a[i] - b[i]. A position is marked when its digit is nonzero and
// the next lower digit is not -1; the highest mark lies at, or one above,
// the true leading one of a - b (a >= b).
module lzan_digit_indicator #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] mark_o
);
    logic [W-1:0] nz_digit;
    logic [W-1:0] neg_digit;

    assign nz_digit  = a_i ^ b_i;
    assign neg_digit = ~a_i & b_i;

    for (genvar i = 0; i < W; i++) begin : g_pos
        if (i == 0) begin : g_lsb
            assign mark_o[i] = nz_digit[i];
        end else begin : g_upper
            assign mark_o[i] = nz_digit[i] & ~neg_digit[i-1];
        end
    end
endmodule

// File: rtl/lzan_lzc.sv
// Leading-zero counter; an all-zero input yields W.
module lzan_lzc #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        count_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec_i[i]) begin
                found   = 1'b1;
                count_o = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/lzan_shifter.sv
// Logarithmic left shifter, one stage per count bit.
module lzan_shifter #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data_i,
    input  logic [CW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [CW+1];

    assign stage[0] = data_i;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        if (STEP >= W) begin : g_flush
            assign stage[k+1] = amt_i[k] ? '0 : stage[k];
        end else begin : g_shift
            assign stage[k+1] = amt_i[k] ? {stage[k][W-1-STEP:0], {STEP{1'b0}}}
                                         : stage[k];
        end
    end

    assign data_o = stage[CW];
endmodule

// File: rtl/lzan_fixup.sv
// One-bit correction after the predicted shift.
module lzan_fixup #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]        shifted_i,
    input  logic [CW-1:0]       est_i,
    input  logic                zero_i,
    output logic [W-1:0]        mant_o,
    output logic [CW-1:0]       count_o,
    output lzan_pkg::fix_kind_e kind_o
);
    import lzan_pkg::*;

    always_comb begin
        if (zero_i) begin
            kind_o  = FIX_ZERO;
            mant_o  = '0;
            count_o = CW'(W);
        end else if (!shifted_i[W-1]) begin
            kind_o  = FIX_ONE;
            mant_o  = {shifted_i[W-2:0], 1'b0};
            count_o = est_i + CW'(1);
        end else begin
            kind_o  = FIX_NONE;
            mant_o  = shifted_i;
            count_o = est_i;
        end
    end
endmodule

// File: rtl/lzan_normalizer.sv
module lzan_normalizer #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = lzan_pkg::count_width(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  op_big,
    input  logic [W-1:0]  op_small,
    output logic          out_valid,
    output logic [W-1:0]  norm_mant,
    output logic [CW-1:0] shift_total,
    output logic [CW-1:0] shift_est,
    output logic          is_zero
);
    import lzan_pkg::*;

    localparam logic [CW-1:0] FULL_SHIFT = CW'(W);

    // Carry-propagate difference, in parallel with the prediction path
    logic [W-1:0]  diff;
    logic          diff_zero;
    assign diff      = op_big - op_small;
    assign diff_zero = (diff == '0);

    // Prediction path
    logic [W-1:0]  marks;
    logic [CW-1:0] est_cnt;

    lzan_digit_indicator #(.W(W)) u_ind (
        .a_i    (op_big),
        .b_i    (op_small),
        .mark_o (marks)
    );

    lzan_lzc #(.W(W), .CW(CW)) u_lzc (
        .vec_i   (marks),
        .count_o (est_cnt)
    );

    // Shift the true difference by the estimate
    logic [W-1:0] shifted;

    lzan_shifter #(.W(W), .CW(CW)) u_shift (
        .data_i (diff),
        .amt_i  (est_cnt),
        .data_o (shifted)
    );

    // Fix-up
    logic [W-1:0]  fix_mant;
    logic [CW-1:0] fix_cnt;
    fix_kind_e     fix_kind;

    lzan_fixup #(.W(W), .CW(CW)) u_fix (
        .shifted_i (shifted),
        .est_i     (est_cnt),
        .zero_i    (diff_zero),
        .mant_o    (fix_mant),
        .count_o   (fix_cnt),
        .kind_o    (fix_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            norm_mant   <= '0;
            shift_total <= '0;
            shift_est   <= '0;
            is_zero     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                norm_mant   <= fix_mant;
                shift_total <= fix_cnt;
                shift_est   <= est_cnt;
                is_zero     <= (fix_kind == FIX_ZERO);
            end
        end
    end

    // Assertions
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && norm_mant == '0 && !is_zero));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_msb_set_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_zero) |-> norm_mant[W-1]);

    assert_est_window_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_zero) |->
        (shift_total == shift_est || shift_total == shift_est + CW'(1)));

    assert_zero_result_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_zero) |->
        (norm_mant == '0 && shift_total == FULL_SHIFT && shift_est == FULL_SHIFT));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(norm_mant) && $stable(shift_total)
                       && $stable(shift_est) && $stable(is_zero)));
endmodule

// File: tb/lzan_normalizer_test.sv
module lzan_normalizer_test;
    localparam int W = 64;
    localparam int CW = $clog2(W + 1);
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [W-1:0]  op_big, op_small;
    logic          out_valid;
    logic [W-1:0]  norm_mant;
    logic [CW-1:0] shift_total, shift_est;
    logic          is_zero;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lzan_normalizer #(.W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_big(op_big), .op_small(op_small),
        .out_valid(out_valid), .norm_mant(norm_mant),
        .shift_total(shift_total), .shift_est(shift_est), .is_zero(is_zero)
    );

    function automatic int ref_lz(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) if (v[i]) return W - 1 - i;
        return W;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one operand pair and check the registered result
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] d, m;
        int lz;
        d  = a - b;
        lz = ref_lz(d);
        m  = (lz >= W) ? '0 : (d << lz);
        @(negedge clk);
        in_valid = 1'b1; op_big = a; op_small = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", "out_valid", W'(out_valid), W'(1));
        check(norm_mant == m, "R3", "norm_mant", norm_mant, m);
        check(int'(shift_total) == lz, "R5", "shift_total", W'(shift_total), W'(lz));
        check(int'(shift_est) <= lz && lz <= int'(shift_est) + 1, "R6",
              "shift_est", W'(shift_est), W'(lz));
        if (d != '0)
            check(norm_mant[W-1] == 1'b1, "R4", "msb", W'(norm_mant[W-1]), W'(1));
        else begin
            check(is_zero == 1'b1, "R7", "is_zero", W'(is_zero), W'(1));
            check(int'(shift_est) == W, "R7", "shift_est", W'(shift_est), W'(W));
        end
        if (d != '0)
            check(is_zero == 1'b0, "R7", "is_zero", W'(is_zero), W'(0));
    endtask

    initial begin
        logic [W-1:0] a, d, held_m;
        logic [CW-1:0] held_t, held_e;
        logic held_z;
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; op_big = '0; op_small = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", W'(out_valid), W'(0));
        check(norm_mant == '0, "R1", "norm_mant", norm_mant, '0);
        check(shift_total == '0 && shift_est == '0, "R1", "counts",
              W'(shift_total), W'(0));
        check(is_zero == 1'b0, "R1", "is_zero", W'(is_zero), W'(0));
        rst = 1'b0;

        // R6: estimate one short, fix-up needed
        apply(64'h8000_0000_0000_0000, 64'd3);
        check(shift_est == CW'(0) && shift_total == CW'(1), "R6", "short case",
              W'(shift_est), W'(0));
        // Borrow run to bit 0: difference 1
        apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
        check(shift_total == CW'(63), "R5", "diff one", W'(shift_total), W'(63));
        // No leading zeros
        apply('1, '0);
        // R7: equal operands
        apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
        check(shift_total == CW'(W) && norm_mant == '0, "R7", "zero result",
              W'(shift_total), W'(W));
        apply(64'h0000_0100_0000_0000, 64'h0000_00FF_0000_0001);

        // R8: idle cycles with changing inputs leave result untouched
        apply(64'h00F0_0000_0000_0000, 64'h0000_0000_0000_0011);
        held_m = norm_mant; held_t = shift_total; held_e = shift_est; held_z = is_zero;
        op_big = 64'hFFFF_0000_0000_0000; op_small = 64'h1;
        @(negedge clk);
        op_big = '0; op_small = '0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid idle", W'(out_valid), W'(0));
        check(norm_mant == held_m, "R8", "norm_mant held", norm_mant, held_m);
        check(shift_total == held_t && shift_est == held_e && is_zero == held_z,
              "R8", "counts held", W'(shift_total), W'(held_t));

        // Random pairs, differences spread over all magnitudes
        for (int n = 0; n < 600; n++) begin
            a = {$urandom, $urandom};
            d = {$urandom, $urandom} >> ($urandom % W);
            if ((n % 7) == 0) d = d & ~(d >> 1);
            if (d > a) d = a;
            apply(a, a - d);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule